// File: doc/BRIEF.md
# Two-Stage Memory Pipeline with Indirect Addressing

This block is the memory section of a load/store pipeline. It sits between execute and writeback and has two memory stages. Four memory operations are supported. A direct load or store uses the address delivered by execute. An indirect load or store first reads a pointer word at that address, then uses the low address bits of that word as the address of the real operand. Direct stores write in the first memory stage. Indirect stores write in the second stage, once the pointer is known.

The data memory is held inside the block. It has two read ports, one per stage, and two write ports, one per stage, so any mix of back-to-back operations flows without a structural stall. Loaded values leave through a writeback latch, and that latch also serves as the main forwarding source. A direct load sitting in the second stage already holds its result, so it is also offered on an early forwarding port.

A hazard output tells execute when its instruction must wait for a load result that cannot be forwarded in time. Fetch, decode and the ALU are not part of this block. In the bench, execute is modelled as a stream of requests.

Top module: `indirect_mem_pipe`

## Requirements
- R1: After reset, `wb_valid`, `efwd_valid` and `stall_req` are low, and every memory word reads as zero.
- R2: A direct load (`in_op` = 2'b00) returns the word at `in_addr` on `wb_data`. `wb_valid` is high and `wb_dest` carries `in_dest`. These appear three rising edges after the edge that captured the request.
- R3: An indirect load (`in_op` = 2'b10) reads the pointer word at `in_addr`. The low 8 bits of that word give a second address, and the word at the second address is returned on the writeback outputs, with the same latency as R2.
- R4: A direct store (`in_op` = 2'b01) writes `in_sdata` at `in_addr` in the first memory stage. Every later load sees the new value.
- R5: An indirect store (`in_op` = 2'b11) writes `in_sdata` in the second memory stage. The target address is the low 8 bits of the pointer word read at `in_addr`.
- R6: Stores never produce a writeback: `wb_valid` stays low in the slot where a store leaves the pipe.
- R7: Any sequence of operations, issued back to back with no gaps, gives the same results as executing them one at a time in program order. In particular, a store in the second stage is seen by a read in the first stage in the same cycle, and a younger store in the first stage is not seen by an older indirect read in the second stage.
- R8: When both stages write the same word in one cycle, the word ends up with the first-stage (younger) store's data.
- R9: The memory holds 256 words of 32 bits, addressed by word. An address, or a pointer value, is used modulo 256.
- R10: While a direct load occupies the second stage, `efwd_valid` is high, and `efwd_dest` and `efwd_data` carry its destination and loaded word. Otherwise `efwd_valid` is low.
- R11: `stall_req` is high when `ex_rs_valid` is high and `ex_rs1` or `ex_rs2` equals the destination of a load (direct or indirect) in the first memory stage.
- R12: `stall_req` is also high when a source matches the destination of an indirect load in the second stage. A direct load in the second stage never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A memory request from execute is present |
| in_op | input | 2 | Operation: 00 load, 01 store, 10 indirect load, 11 indirect store |
| in_addr | input | 32 | Word address computed by execute (used modulo depth) |
| in_sdata | input | 32 | Store data |
| in_dest | input | 5 | Destination register of a load |
| ex_rs_valid | input | 1 | The instruction in execute reads registers |
| ex_rs1 | input | 5 | First source register of the instruction in execute |
| ex_rs2 | input | 5 | Second source register of the instruction in execute |
| wb_valid | output | 1 | Writeback latch holds a load result |
| wb_dest | output | 5 | Destination of the writeback result |
| wb_data | output | 32 | Writeback / forwarded load value |
| efwd_valid | output | 1 | Second stage holds a direct load whose value is ready |
| efwd_dest | output | 5 | Destination of that direct load |
| efwd_data | output | 32 | Value of that direct load |
| stall_req | output | 1 | Execute must hold its instruction this cycle |

## Verification
The assertions check several things on every cycle. Each load reaches writeback after a fixed three-edge latency with its destination intact. An indirect load writes back the word from the second read port, and a store slot produces no writeback. A write lands in the memory array, and a same-cycle write collision keeps the younger data. A load followed by a dependent reader in execute raises the stall at one or two cycles of distance. The bench's scenarios cover the rest. These are the end-to-end data values compared against a program-order model of the memory, the same-cycle visibility between the two stages, address and pointer wrapping, the zeroed memory after reset, and the case where a direct load in the second stage is forwarded rather than stalled.

// File: rtl/imp_pkg.sv
package imp_pkg;

   typedef enum logic [1:0] {
      OP_LW  = 2'b00,
      OP_SW  = 2'b01,
      OP_LWI = 2'b10,
      OP_SWI = 2'b11
   } mop_e;

   function automatic logic op_is_store(mop_e op);
      return op[0];
   endfunction

   function automatic logic op_is_ind(mop_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/imp_dpram.sv
module imp_dpram #(
   parameter int DATA_W         = 32,
   parameter int DEPTH          = 256,
   parameter int ADDR_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   // read port of the first stage (sees a same-cycle second-stage store)
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [DATA_W-1:0] ra_data,
   // read port of the second stage
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_data,
   // write port of the first stage (younger)
   input  logic              w1_en,
   input  logic [ADDR_W-1:0] w1_addr,
   input  logic [DATA_W-1:0] w1_data,
   // write port of the second stage (older)
   input  logic              w2_en,
   input  logic [ADDR_W-1:0] w2_addr,
   input  logic [DATA_W-1:0] w2_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   // The older store is in flight in the same cycle; the younger read must see it.
   assign ra_data = (w2_en && (w2_addr == ra_addr)) ? w2_data : cells[ra_addr];
   assign rb_data = cells[rb_addr];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else begin
               // older store first, younger store last so it wins a collision
               if (w2_en) cells[w2_addr] <= w2_data;
               if (w1_en) cells[w1_addr] <= w1_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (w2_en) cells[w2_addr] <= w2_data;
            if (w1_en) cells[w1_addr] <= w1_data;
         end
      end
   endgenerate

   // R4: a first-stage store is always present in the array afterwards
   a_r4_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
      w1_en |=> cells[$past(w1_addr)] == $past(w1_data));

   // R5: a second-stage store lands unless overruled by a younger one
   a_r5_ind_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
      w2_en && !(w1_en && (w1_addr == w2_addr))
      |=> cells[$past(w2_addr)] == $past(w2_data));

   // R8: on a collision the younger data survives
   a_r8_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
      w1_en && w2_en && (w1_addr == w2_addr)
      |=> cells[$past(w2_addr)] == $past(w1_data));

endmodule

// File: rtl/imp_mem1.sv
module imp_mem1
   import imp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int DEST_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  mop_e              in_op,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_sdata,
   input  logic [DEST_W-1:0] in_dest,
   // memory ports
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   // stage state seen by the hazard logic
   output logic              s1_valid,
   output logic              s1_is_load,
   output logic [DEST_W-1:0] s1_dest,
   // towards the second stage
   output mop_e              nx_op,
   output logic [DATA_W-1:0] nx_word,
   output logic [DATA_W-1:0] nx_sdata
);

   logic              v_q;
   mop_e              op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] sd_q;
   logic [DEST_W-1:0] dest_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         op_q   <= OP_LW;
         addr_q <= '0;
         sd_q   <= '0;
         dest_q <= '0;
      end else begin
         v_q    <= in_valid;
         op_q   <= in_op;
         addr_q <= in_addr;
         sd_q   <= in_sdata;
         dest_q <= in_dest;
      end
   end

   assign rd_addr    = addr_q;
   assign wr_en      = v_q && (op_q == OP_SW);
   assign wr_addr    = addr_q;
   assign wr_data    = sd_q;

   assign s1_valid   = v_q;
   assign s1_is_load = !op_is_store(op_q);
   assign s1_dest    = dest_q;

   assign nx_op      = op_q;
   assign nx_word    = rd_data;
   assign nx_sdata   = sd_q;

endmodule

// File: rtl/imp_mem2.sv
module imp_mem2
   import imp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int DEST_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p_valid,
   input  mop_e              p_op,
   input  logic [DEST_W-1:0] p_dest,
   input  logic [DATA_W-1:0] p_word,
   input  logic [DATA_W-1:0] p_sdata,
   // memory ports
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   // stage state
   output logic              s2_valid,
   output mop_e              s2_op,
   output logic [DEST_W-1:0] s2_dest,
   output logic [DATA_W-1:0] s2_word,
   // writeback latch
   output logic              wb_valid,
   output logic [DEST_W-1:0] wb_dest,
   output logic [DATA_W-1:0] wb_data
);

   logic              v_q;
   mop_e              op_q;
   logic [DEST_W-1:0] dest_q;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] sd_q;
   logic [DATA_W-1:0] result;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         op_q   <= OP_LW;
         dest_q <= '0;
         word_q <= '0;
         sd_q   <= '0;
      end else begin
         v_q    <= p_valid;
         op_q   <= p_op;
         dest_q <= p_dest;
         word_q <= p_word;
         sd_q   <= p_sdata;
      end
   end

   // the word read in the first stage is the pointer for indirect operations
   assign rd_addr = word_q[ADDR_W-1:0];
   assign wr_en   = v_q && (op_q == OP_SWI);
   assign wr_addr = word_q[ADDR_W-1:0];
   assign wr_data = sd_q;

   // opcode-steered selection of the writeback value
   assign result  = op_is_ind(op_q) ? rd_data : word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_dest  <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= v_q && !op_is_store(op_q);
         wb_dest  <= dest_q;
         wb_data  <= result;
      end
   end

   assign s2_valid = v_q;
   assign s2_op    = op_q;
   assign s2_dest  = dest_q;
   assign s2_word  = word_q;

   // R6: a store leaving the second stage never reaches writeback
   a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      v_q && op_is_store(op_q) |=> !wb_valid);

   // R3: an indirect load writes back what the second read port returned
   a_r3_ind_result: assert property (@(posedge clk) disable iff (!rst_n)
      v_q && (op_q == OP_LWI) |=> wb_valid && (wb_data == $past(rd_data)));

endmodule

// File: rtl/imp_hazard.sv
module imp_hazard #(
   parameter int DEST_W = 5,
   parameter int NSRC   = 2
) (
   input  logic                        s1_valid,
   input  logic                        s1_is_load,
   input  logic [DEST_W-1:0]           s1_dest,
   input  logic                        s2_valid,
   input  logic                        s2_is_lwi,
   input  logic [DEST_W-1:0]           s2_dest,
   input  logic                        rs_valid,
   input  logic [NSRC-1:0][DEST_W-1:0] rs,
   output logic                        stall_req
);

   logic [NSRC-1:0] hit1;
   logic [NSRC-1:0] hit2;

   genvar g;
   generate
      for (g = 0; g < NSRC; g++) begin : g_src
         assign hit1[g] = (rs[g] == s1_dest);
         assign hit2[g] = (rs[g] == s2_dest);
      end
   endgenerate

   // a load in the first stage cannot feed execute yet; an indirect load in
   // the second stage is only ready once it reaches the writeback latch
   assign stall_req = rs_valid &&
                      ((s1_valid && s1_is_load && |hit1) ||
                       (s2_valid && s2_is_lwi  && |hit2));

endmodule

// File: rtl/indirect_mem_pipe.sv
module indirect_mem_pipe
   import imp_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int DEPTH          = 256,
   parameter int DEST_W         = 5,
   parameter bit EARLY_FWD      = 1'b1,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [DATA_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_sdata,
   input  logic [DEST_W-1:0] in_dest,
   input  logic              ex_rs_valid,
   input  logic [DEST_W-1:0] ex_rs1,
   input  logic [DEST_W-1:0] ex_rs2,
   output logic              wb_valid,
   output logic [DEST_W-1:0] wb_dest,
   output logic [DATA_W-1:0] wb_data,
   output logic              efwd_valid,
   output logic [DEST_W-1:0] efwd_dest,
   output logic [DATA_W-1:0] efwd_data,
   output logic              stall_req
);

   localparam int ADDR_W = $clog2(DEPTH);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < ADDR_W) begin : g_bad_width
         $error("DATA_W must hold a full word address");
      end
      if (DATA_W > ADDR_W) begin : g_hi_bits
         logic unused_addr_hi;
         assign unused_addr_hi = ^in_addr[DATA_W-1:ADDR_W];
      end
   endgenerate

   mop_e              op_in;
   logic [ADDR_W-1:0] ra_addr, rb_addr, w1_addr, w2_addr;
   logic [DATA_W-1:0] ra_data, rb_data, w1_data, w2_data;
   logic              w1_en, w2_en;
   logic              s1_valid, s1_is_load;
   logic [DEST_W-1:0] s1_dest;
   mop_e              nx_op;
   logic [DATA_W-1:0] nx_word, nx_sdata;
   logic              s2_valid;
   mop_e              s2_op;
   logic [DEST_W-1:0] s2_dest;
   logic [DATA_W-1:0] s2_word;

   assign op_in = mop_e'(in_op);

   imp_dpram #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_ram (
      .clk(clk), .rst_n(rst_n),
      .ra_addr(ra_addr), .ra_data(ra_data),
      .rb_addr(rb_addr), .rb_data(rb_data),
      .w1_en(w1_en), .w1_addr(w1_addr), .w1_data(w1_data),
      .w2_en(w2_en), .w2_addr(w2_addr), .w2_data(w2_data)
   );

   imp_mem1 #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_mem1 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_op(op_in), .in_addr(in_addr[ADDR_W-1:0]),
      .in_sdata(in_sdata), .in_dest(in_dest),
      .rd_addr(ra_addr), .rd_data(ra_data),
      .wr_en(w1_en), .wr_addr(w1_addr), .wr_data(w1_data),
      .s1_valid(s1_valid), .s1_is_load(s1_is_load), .s1_dest(s1_dest),
      .nx_op(nx_op), .nx_word(nx_word), .nx_sdata(nx_sdata)
   );

   imp_mem2 #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_mem2 (
      .clk(clk), .rst_n(rst_n),
      .p_valid(s1_valid), .p_op(nx_op), .p_dest(s1_dest),
      .p_word(nx_word), .p_sdata(nx_sdata),
      .rd_addr(rb_addr), .rd_data(rb_data),
      .wr_en(w2_en), .wr_addr(w2_addr), .wr_data(w2_data),
      .s2_valid(s2_valid), .s2_op(s2_op), .s2_dest(s2_dest), .s2_word(s2_word),
      .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data)
   );

   imp_hazard #(.DEST_W(DEST_W), .NSRC(2)) u_hazard (
      .s1_valid(s1_valid), .s1_is_load(s1_is_load), .s1_dest(s1_dest),
      .s2_valid(s2_valid), .s2_is_lwi(s2_op == OP_LWI), .s2_dest(s2_dest),
      .rs_valid(ex_rs_valid), .rs({ex_rs2, ex_rs1}),
      .stall_req(stall_req)
   );

   generate
      if (EARLY_FWD) begin : g_efwd
         assign efwd_valid = s2_valid && (s2_op == OP_LW);
         assign efwd_dest  = s2_dest;
         assign efwd_data  = s2_word;
      end else begin : g_no_efwd
         logic unused_efwd;
         assign unused_efwd = ^s2_word;
         assign efwd_valid  = 1'b0;
         assign efwd_dest   = '0;
         assign efwd_data   = '0;
      end
   endgenerate

   // R2: every load reaches writeback three edges later with its destination
   a_r2_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_op[0] |-> ##3 (wb_valid && (wb_dest == $past(in_dest, 3))));

   // R11: a load captured on the previous edge blocks a dependent reader
   a_r11_mem1_stall: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(in_valid && !in_op[0]) && ex_rs_valid &&
      (ex_rs1 == $past(in_dest)) |-> stall_req);

   // R12: an indirect load two edges back still blocks a dependent reader
   a_r12_mem2_stall: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n, 2) && $past(in_valid && (in_op == 2'b10), 2) && ex_rs_valid &&
      (ex_rs2 == $past(in_dest, 2)) |-> stall_req);

endmodule

// File: tb/test_indirect_mem_pipe.sv
`timescale 1ns/1ps
module test_indirect_mem_pipe;

   localparam int DW    = 32;
   localparam int DEPTH = 256;
   localparam int RW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_op = 2'b00;
   logic [DW-1:0] in_addr = '0;
   logic [DW-1:0] in_sdata = '0;
   logic [RW-1:0] in_dest = '0;
   logic          ex_rs_valid = 1'b0;
   logic [RW-1:0] ex_rs1 = '0;
   logic [RW-1:0] ex_rs2 = '0;
   logic          wb_valid, efwd_valid, stall_req;
   logic [RW-1:0] wb_dest, efwd_dest;
   logic [DW-1:0] wb_data, efwd_data;

   always #2.5 clk = ~clk;

   indirect_mem_pipe i_indirect_mem_pipe (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_op(in_op), .in_addr(in_addr),
      .in_sdata(in_sdata), .in_dest(in_dest),
      .ex_rs_valid(ex_rs_valid), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
      .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data),
      .efwd_valid(efwd_valid), .efwd_dest(efwd_dest), .efwd_data(efwd_data),
      .stall_req(stall_req)
   );

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;

   bit [31:0] ref_mem [DEPTH];

   typedef struct {
      bit        v;
      bit [1:0]  op;
      bit [4:0]  dest;
      bit [31:0] data;
      string     tag;
   } ent_t;

   ent_t pq[$];

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 100000) begin
         miscompares++;
         $display("FAIL R1 watchdog: got %0d cycles expected fewer", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // program-order model: each operation completes before the next one
   function automatic ent_t run_ref(bit v, bit [1:0] op, bit [31:0] addr,
                                    bit [31:0] sdata, bit [4:0] dest, string tag);
      ent_t e;
      int a, p;
      e.v = v; e.op = op; e.dest = dest; e.data = '0; e.tag = tag;
      if (v) begin
         a = int'(addr % DEPTH);
         p = int'(ref_mem[a] % DEPTH);
         case (op)
            2'b00: e.data = ref_mem[a];
            2'b01: ref_mem[a] = sdata;
            2'b10: e.data = ref_mem[p];
            default: ref_mem[p] = sdata;
         endcase
      end
      return e;
   endfunction

   task automatic step(bit v, bit [1:0] op, bit [31:0] addr, bit [31:0] sdata,
                       bit [4:0] dest, bit rsv, bit [4:0] rs1, bit [4:0] rs2,
                       string tag);
      ent_t e, m1e, m2e;
      bit h1, h2, is_ld;
      string stag;
      @(negedge clk);
      // writeback of the operation issued three steps ago
      e = pq.pop_front();
      is_ld = e.v && !e.op[0];
      chk(e.tag, "wb_valid", 32'(wb_valid), 32'(is_ld));
      if (is_ld) begin
         chk(e.tag, "wb_dest", 32'(wb_dest), 32'(e.dest));
         chk(e.tag, "wb_data", wb_data, e.data);
      end
      m2e = pq[0];
      m1e = pq[1];
      // R10 early forward of a direct load in the second stage
      chk("R10", "efwd_valid", 32'(efwd_valid), 32'(m2e.v && m2e.op == 2'b00));
      if (m2e.v && m2e.op == 2'b00) begin
         chk("R10", "efwd_dest", 32'(efwd_dest), 32'(m2e.dest));
         chk("R10", "efwd_data", efwd_data, m2e.data);
      end
      in_valid = v; in_op = op; in_addr = addr; in_sdata = sdata; in_dest = dest;
      ex_rs_valid = rsv; ex_rs1 = rs1; ex_rs2 = rs2;
      #1;
      h1 = rsv && m1e.v && !m1e.op[0] && (m1e.dest == rs1 || m1e.dest == rs2);
      h2 = rsv && m2e.v && (m2e.op == 2'b10) && (m2e.dest == rs1 || m2e.dest == rs2);
      if (h1)      stag = "R11";
      else if (h2) stag = "R12";
      else if (m2e.v && m2e.op == 2'b00) stag = "R12";
      else         stag = "R11";
      chk(stag, "stall_req", 32'(stall_req), 32'(h1 || h2));
      pq.push_back(run_ref(v, op, addr, sdata, dest, tag));
   endtask

   task automatic mop(bit [1:0] op, bit [31:0] addr, bit [31:0] sdata, bit [4:0] dest,
                      string tag);
      step(1'b1, op, addr, sdata, dest, 1'b0, 5'd0, 5'd0, tag);
   endtask

   task automatic bub(bit rsv, bit [4:0] rs);
      step(1'b0, 2'b00, '0, '0, '0, rsv, rs, rs, "R11");
   endtask

   function automatic bit [31:0] fill_val(int a);
      return {8'(a * 3 + 1), 8'(a * 7), 8'(a), 8'(a * 13 + 5)};
   endfunction

   initial begin
      ent_t blank;
      int x, y, z;
      blank.v = 1'b0; blank.op = 2'b00; blank.dest = '0; blank.data = '0; blank.tag = "R1";
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

      // R1: state during and right after reset
      ex_rs_valid = 1'b1; ex_rs1 = 5'd0; ex_rs2 = 5'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "wb_valid in reset", 32'(wb_valid), 32'd0);
      chk("R1", "efwd_valid in reset", 32'(efwd_valid), 32'd0);
      chk("R1", "stall_req in reset", 32'(stall_req), 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) pq.push_back(blank);
      bub(1'b1, 5'd0);

      // R1: memory cleared
      mop(2'b00, 32'd7, '0, 5'd1, "R1");
      mop(2'b10, 32'd9, '0, 5'd2, "R1");
      mop(2'b00, 32'd255, '0, 5'd3, "R1");

      // R4: fill every word with direct stores, back to back
      for (int a = 0; a < DEPTH; a++) mop(2'b01, 32'(a), fill_val(a), 5'd0, "R4");
      for (int a = 0; a < 16; a++) mop(2'b00, 32'(a * 17), '0, 5'(a % 4), "R4");

      // R9: address wrap on direct access and on pointers
      mop(2'b00, 32'h0000_0105, '0, 5'd1, "R9");
      mop(2'b01, 32'h0000_01FF, 32'hA5A5_0033, 5'd0, "R9");
      mop(2'b00, 32'd255, '0, 5'd2, "R9");
      mop(2'b01, 32'd60, 32'h1234_5678, 5'd0, "R9");
      mop(2'b10, 32'd60, '0, 5'd3, "R9");

      // R3: isolated indirect loads
      for (int i = 0; i < 4; i++) begin
         mop(2'b10, 32'(i * 11 + 3), '0, 5'(i), "R3");
         bub(1'b0, 5'd0);
         bub(1'b0, 5'd0);
      end

      // R7: indirect loads back to back
      for (int i = 0; i < 8; i++) mop(2'b10, 32'(i * 5), '0, 5'(i % 4), "R7");

      // R5: indirect store, then read its target
      x = int'(ref_mem[20] % DEPTH);
      mop(2'b11, 32'd20, 32'hDEAD_BEEF, 5'd0, "R5");
      bub(1'b0, 5'd0);
      bub(1'b0, 5'd0);
      mop(2'b00, 32'(x), '0, 5'd2, "R5");

      // R8: second-stage and first-stage stores to one word in one cycle
      x = int'(ref_mem[40] % DEPTH);
      mop(2'b11, 32'd40, 32'h1111_1111, 5'd0, "R8");
      mop(2'b01, 32'(x), 32'h2222_2222, 5'd0, "R8");
      bub(1'b0, 5'd0);
      mop(2'b00, 32'(x), '0, 5'd1, "R8");

      // R7: older indirect store seen by a younger read in the same cycle
      y = int'(ref_mem[50] % DEPTH);
      mop(2'b11, 32'd50, 32'h3333_4444, 5'd0, "R7");
      mop(2'b00, 32'(y), '0, 5'd3, "R7");
      // R7: store then an indirect load using that word as its pointer
      mop(2'b01, 32'd70, 32'h0000_00C8, 5'd0, "R7");
      mop(2'b10, 32'd70, '0, 5'd2, "R7");
      // R7: younger store must not affect an older indirect read
      z = int'(ref_mem[80] % DEPTH);
      mop(2'b10, 32'd80, '0, 5'd1, "R7");
      mop(2'b01, 32'(z), 32'h5555_6666, 5'd0, "R7");
      mop(2'b00, 32'(z), '0, 5'd0, "R7");

      // R11 / R12: hazard distances
      mop(2'b00, 32'd100, '0, 5'd2, "R2");
      bub(1'b1, 5'd2);
      mop(2'b10, 32'd101, '0, 5'd3, "R3");
      bub(1'b1, 5'd3);
      bub(1'b1, 5'd3);
      mop(2'b00, 32'd102, '0, 5'd1, "R2");
      bub(1'b0, 5'd0);
      bub(1'b1, 5'd1);
      mop(2'b10, 32'd103, '0, 5'd0, "R3");
      bub(1'b0, 5'd0);
      bub(1'b1, 5'd0);
      mop(2'b01, 32'd104, 32'h7, 5'd2, "R6");
      bub(1'b1, 5'd2);

      // mixed random traffic against the program-order model
      for (int i = 0; i < 3000; i++) begin
         bit v;
         bit [1:0] op;
         string t;
         v  = ($urandom % 4) != 0;
         op = 2'($urandom % 4);
         case (op)
            2'b00: t = "R2";
            2'b10: t = "R3";
            default: t = "R6";
         endcase
         step(v, op, 32'($urandom % 300), $urandom, 5'($urandom % 4),
              1'($urandom % 2), 5'($urandom % 4), 5'($urandom % 4), t);
      end

      for (int i = 0; i < 4; i++) bub(1'b0, 5'd0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule